// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

A memory-mapped timer with a 64-bit up-counter and a 64-bit period. Each is split into a low word and a high word on a plain 32-bit register bus. When the timer is set to its watchdog mode, software arms it with a two-step 16-bit key handshake in the upper half of the watchdog control word. From the first accepted arming key onward, every configuration word is frozen. The only exception is the key field, which keeps taking the same two-key handshake to service the watchdog.

If the counter reaches the period while the watchdog is armed and no service has cleared it, a sticky timeout flag is set, the counter freezes and a reset request is driven for a fixed number of clocks. Only the system reset clears the enable bit, the flag and the frozen counter.

Top module: `keyed_wdt64`

## Requirements
- R1: After reset, every readable word (offsets 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28) reads zero and `wd_rst_o` is low.
- R2: While the watchdog is not armed, software can write and read back the period words (0x18 low, 0x1C high), the run-mode field (bits 7:6 at 0x20) and the global word at 0x24. The global word holds bit 0 for the low-half release, bit 1 for the high-half release and bits 3:2 for the timer mode.
- R3: The 64-bit counter (0x10 low, 0x14 high) steps by one on each clock, with carry into the high word, when the run mode is nonzero and both release bits are set. Otherwise it holds its value. Software may load either word while the watchdog is unarmed.
- R4: Writing 0x28 with key 0xA5C6 in bits 31:16 and bit 14 set moves the watchdog to pre-active, but only if the timer mode is 2. A following write with key 0xDA7E and bit 14 set makes it active. Bit 14 then reads 1.
- R5: From pre-active onward, writes to 0x10 through 0x24 are ignored, and so are the non-key bits written to 0x28.
- R6: While active, key 0xA5C6 followed by key 0xDA7E clears the 64-bit counter to zero, and it then resumes counting.
- R7: A key other than the one expected in the current state drops the handshake back to waiting for the first key, with no other effect.
- R8: When the counter equals the period on a clock where the watchdog is active and counting, bit 15 of 0x28 becomes 1 and the counter freezes.
- R9: Expiry drives `wd_rst_o` high for exactly PULSE_LEN (16) clocks.
- R10: If the closing service key lands on the same clock as expiry, expiry wins: the flag sets and the counter is not cleared.
- R11: Software cannot clear the enable bit or the flag. Only `rst_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| reg_addr | input | ADDR_W | Byte address of the accessed word |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read enable; read data is zero when low |
| reg_rdata | output | 32 | Combinational read data |
| wd_rst_o | output | 1 | Reset request, high for PULSE_LEN clocks after expiry |

## Verification
Two events can fall on the same clock edge: a service that completes and an expiry on that very edge. The bench provokes this by counting clocks from a known service point. It first places the closing key one clock before the counter reaches the period, which must be accepted and return the counter to zero. It then places the closing key exactly on the expiry clock, where the flag must be set and the counter must stay at the period value.

// File: rtl/keyed_wdt64.sv
module keyed_wdt64 #(
  parameter int ADDR_W    = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              wd_rst_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_PLO = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_PHI = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_RUN = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_GLB = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_WDC = ADDR_W'('h28);
  localparam logic [15:0] KEY_1 = 16'hA5C6;
  localparam logic [15:0] KEY_2 = 16'hDA7E;

  typedef enum logic [1:0] {S_OFF, S_PRE, S_ACT, S_SRV} wd_st_t;

  wd_st_t       st;
  logic [63:0]  cnt, prd;
  logic [1:0]   run_mode, tmr_mode;
  logic         rel_lo, rel_hi, wd_en, wd_flag;
  logic [PW-1:0] pulse;

  wire locked   = (st != S_OFF);
  wire cfg_wr   = reg_wr && !locked;
  wire key_wr   = reg_wr && (reg_addr == A_WDC);
  wire [15:0] key = reg_wdata[31:16];
  wire live     = (st == S_ACT) || (st == S_SRV);
  wire running  = (run_mode != 2'd0) && rel_lo && rel_hi && !wd_flag;
  wire expire   = live && running && (cnt == prd);
  wire svc_done = (st == S_SRV) && key_wr && (key == KEY_2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_OFF;
      wd_en <= 1'b0;
    end else if (key_wr) begin
      case (st)
        S_OFF: if (key == KEY_1 && reg_wdata[14] && tmr_mode == 2'd2) begin
                 st    <= S_PRE;
                 wd_en <= 1'b1;
               end
        S_PRE: if (key == KEY_2 && reg_wdata[14]) st <= S_ACT;
        S_ACT: if (key == KEY_1) st <= S_SRV;
        default: st <= S_ACT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd      <= '0;
      run_mode <= '0;
      tmr_mode <= '0;
      rel_lo   <= 1'b0;
      rel_hi   <= 1'b0;
    end else if (cfg_wr) begin
      if (reg_addr == A_PLO) prd[31:0]  <= reg_wdata;
      if (reg_addr == A_PHI) prd[63:32] <= reg_wdata;
      if (reg_addr == A_RUN) run_mode   <= reg_wdata[7:6];
      if (reg_addr == A_GLB) {tmr_mode, rel_hi, rel_lo} <= reg_wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             cnt <= '0;
    else if (expire || wd_flag)             cnt <= cnt;
    else if (svc_done)                      cnt <= '0;
    else if (cfg_wr && reg_addr == A_CLO)   cnt[31:0]  <= reg_wdata;
    else if (cfg_wr && reg_addr == A_CHI)   cnt[63:32] <= reg_wdata;
    else if (running)                       cnt <= cnt + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_flag <= 1'b0;
      pulse   <= '0;
    end else if (expire) begin
      wd_flag <= 1'b1;
      pulse   <= PW'(PULSE_LEN);
    end else if (pulse != '0) begin
      pulse   <= pulse - PW'(1);
    end
  end

  assign wd_rst_o = (pulse != '0);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_CLO:   reg_rdata = cnt[31:0];
        A_CHI:   reg_rdata = cnt[63:32];
        A_PLO:   reg_rdata = prd[31:0];
        A_PHI:   reg_rdata = prd[63:32];
        A_RUN:   reg_rdata = {24'd0, run_mode, 6'd0};
        A_GLB:   reg_rdata = {28'd0, tmr_mode, rel_hi, rel_lo};
        A_WDC:   reg_rdata = {16'd0, wd_flag, wd_en, 14'd0};
        default: reg_rdata = '0;
      endcase
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) wd_flag |=> wd_flag); // R8
  AST_CNT_FROZEN:  assert property (@(posedge clk) disable iff (!rst_n) wd_flag |=> $stable(cnt)); // R8
  AST_EN_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) wd_en |=> wd_en); // R11
  AST_PRD_LOCKED:  assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(prd)); // R5
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(wd_flag) |-> wd_rst_o); // R9
  AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (expire && svc_done) |=> (wd_flag && cnt != 64'd0)); // R10
endmodule

// File: tb/keyed_wdt64_test.sv
module keyed_wdt64_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        wd_rst_o;

  int checks = 0;
  int fails  = 0;

  keyed_wdt64 uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .wd_rst_o(wd_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup_wd(input logic [31:0] p);
    wr(8'h18, p); wr(8'h1C, 32'd0);
    wr(8'h10, 32'd0); wr(8'h14, 32'd0);
    wr(8'h24, 32'h0000_000B);
    wr(8'h20, 32'h0000_0080);
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h28, 32'hDA7E_4000);
  endtask

  task automatic service();
    wr(8'h28, 32'hA5C6_0000);
    wr(8'h28, 32'hDA7E_0000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int a = 8'h10; a <= 8'h28; a += 4) begin
      rd(8'(a), d);
      check("R1 reset word", d, 32'd0);
    end
    check("R1 reset output", {31'd0, wd_rst_o}, 32'd0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    do_reset();
    wr(8'h18, 32'h1234_5678); wr(8'h1C, 32'h0000_00AB);
    wr(8'h20, 32'h0000_0040); wr(8'h24, 32'h0000_0009);
    rd(8'h18, d); check("R2 period low", d, 32'h1234_5678);
    rd(8'h1C, d); check("R2 period high", d, 32'h0000_00AB);
    rd(8'h20, d); check("R2 run mode", d, 32'h0000_0040);
    rd(8'h24, d); check("R2 global", d, 32'h0000_0009);
    wr(8'h10, 32'd5);
    idle(3);
    rd(8'h10, d); check("R3 hold without high release", d, 32'd5);
  endtask

  task automatic t_count();
    logic [31:0] d;
    do_reset();
    wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 32'd0);
    wr(8'h24, 32'h0000_0003);
    wr(8'h20, 32'h0000_0080);
    idle(4);
    rd(8'h10, d); check("R3 low after carry", d, 32'd2);
    rd(8'h14, d); check("R3 high after carry", d, 32'd1);
  endtask

  task automatic t_arm();
    logic [31:0] d;
    do_reset();
    wr(8'h24, 32'h0000_0003);
    wr(8'h28, 32'hA5C6_4000); wr(8'h28, 32'hDA7E_4000);
    rd(8'h28, d); check("R4 arm refused outside watchdog mode", d, 32'd0);
    wr(8'h18, 32'd7);
    rd(8'h18, d); check("R4 still unlocked", d, 32'd7);
    wr(8'h24, 32'h0000_000B);
    wr(8'h28, 32'hA5C6_4000); wr(8'h28, 32'hDA7E_4000);
    rd(8'h28, d); check("R4 armed enable bit", d, 32'h0000_4000);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(8'h18, 32'h0000_0123);
    rd(8'h18, d); check("R5 period locked", d, 32'd7);
    wr(8'h20, 32'h0000_00C0);
    rd(8'h20, d); check("R5 run mode locked", d, 32'd0);
    wr(8'h24, 32'h0000_0000);
    rd(8'h24, d); check("R5 global locked", d, 32'h0000_000B);
    wr(8'h28, 32'h0000_0000);
    rd(8'h28, d); check("R11 enable not clearable", d, 32'h0000_4000);
  endtask

  task automatic t_service();
    logic [31:0] d;
    do_reset();
    setup_wd(32'd40);
    service();
    rd(8'h10, d); check("R6 counter cleared", d, 32'd0);
    idle(5);
    rd(8'h10, d); check("R6 counting resumes", d, 32'd5);
    service();
    wr(8'h28, 32'hA5C6_0000);
    wr(8'h28, 32'h1234_0000);
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h10, d); check("R7 wrong key voids service", d, 32'd3);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    int hi;
    do_reset();
    setup_wd(32'd40);
    service();
    idle(40);
    rd(8'h28, d); check("R8 no flag before expiry", d, 32'h0000_4000);
    check("R9 output low before expiry", {31'd0, wd_rst_o}, 32'd0);
    idle(1);
    rd(8'h28, d); check("R8 flag set", d, 32'h0000_C000);
    hi = 0;
    for (int i = 0; i < 24; i++) begin
      if (wd_rst_o) hi++;
      @(negedge clk);
    end
    check("R9 pulse length", 32'(hi), 32'd16);
    service();
    rd(8'h10, d); check("R8 counter frozen", d, 32'd40);
    rd(8'h28, d); check("R11 flag not clearable", d, 32'h0000_C000);
    do_reset();
    rd(8'h28, d); check("R11 reset clears", d, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    do_reset();
    setup_wd(32'd20);
    service();
    idle(18);
    service();
    rd(8'h28, d); check("R10 just-in-time service no flag", d, 32'h0000_4000);
    rd(8'h10, d); check("R10 just-in-time service clears", d, 32'd0);
    idle(19);
    service();
    rd(8'h28, d); check("R10 same-clock expiry wins flag", d, 32'h0000_C000);
    rd(8'h10, d); check("R10 counter not cleared", d, 32'd20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_config();
    t_count();
    t_arm();
    t_lock();
    t_service();
    t_expire();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule